// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block walks a device through one requested lifecycle change. When idle it accepts a request carrying a target state and an unlock token. It then steps through a fixed pipeline: switch to the bypass clock, check that the transition counter can grow, program the counter, check that the move is legal, hash the token, wipe flash when the target is the return-for-repair state, compare the hash against the expected token in two halves, and program the new state. Every step that can fail drops into a terminal post-transition state and sets a sticky error flag. Any later step is then never reached.

The counter/state programmer, the hash engine and the flash wipe engine sit outside the block. Each one is reached through a plain level request with an acknowledge. Two separate escalation inputs force the sequencer into a sticky escalate state from almost anywhere. A scrap request in idle parks it for good. The state register holds sparse codewords, and a corrupted value is caught and routed to an invalid state.

Top module: `xition_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in RESET (state_o = 0) with all error flags and request outputs low. The next cycle it always moves to IDLE (1), even when escalation is asserted.
- R2: A request in IDLE captures tgt_i and token_i. A run with no failures visits CLKMUX 2, CNT_INC 3, CNT_PROG 4, LEGAL 5, HASH 6, WIPE 7, CMP_LO 8, CMP_HI 9 and PROG 10, in that order, and ends in POST 11. hash_tok_o carries the captured token during HASH, and prog_tgt_o carries the captured target during PROG.
- R3: WIPE holds wipe_req_o high until wipe_ack_i when the captured target equals RMA_TGT (default 14). For any other target it spends exactly one cycle in WIPE with wipe_req_o low.
- R4: Any of the following moves to POST with err_flow_o set: cnt_full_i in CNT_INC, prog_err_i with prog_ack_i in CNT_PROG or PROG, or hash_err_i with hash_ack_i in HASH. CNT_PROG, HASH and PROG wait while their acknowledge is low.
- R5: LEGAL continues only when the captured target is strictly greater than cur_lc_i. Otherwise it moves to POST with err_trans_o set.
- R6: CMP_LO compares bits [TOK_W/2-1:0] of the captured hash with exp_tok_i, and CMP_HI compares the upper half. A mismatch moves to POST with err_tok_o set.
- R7: CMP_HI stays in place while prog_rdy_i is low and makes its compare only once prog_rdy_i is high.
- R8: scrap_i in IDLE moves to SCRAP (12) and takes priority over a request. scrap_i has no effect in any other state. SCRAP ignores escalation.
- R9: While esc0_i or esc1_i is high (either alone is enough), every state other than RESET and SCRAP moves to ESC (13) on the next cycle. This includes POST and INVALID, and escalation takes priority over all other inputs.
- R10: POST, ESC and INVALID hold without escalation. ESC never leaves, and only reset leaves SCRAP.
- R11: The state register holds the Hamming(7,4) codeword of (state index + 1), laid out {d3..d0, p3, p2, p1} with p1=d0^d1^d3, p2=d0^d2^d3 and p3=d1^d2^d3. Any other value, such as 7'h03, makes state_o read INVALID (14) at once, and the next state is INVALID whatever the inputs.
- R12: hash_req_o is high only in HASH. prog_req_o is high only in CNT_PROG and PROG, and prog_cnt_o is high only in CNT_PROG. wipe_req_o is high only in WIPE. clk_byp_o is high in states 2 to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transition request (sampled in IDLE) |
| tgt_i | input | LC_W | Requested target lifecycle state |
| cur_lc_i | input | LC_W | Current lifecycle state |
| token_i | input | TOK_W | Unlock token supplied with the request |
| exp_tok_i | input | TOK_W | Expected hashed token for the target |
| scrap_i | input | 1 | Scrap request (IDLE only) |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| cnt_full_i | input | 1 | Transition counter cannot grow |
| prog_ack_i | input | 1 | Programmer acknowledge |
| prog_err_i | input | 1 | Programmer error, valid with ack |
| prog_rdy_i | input | 1 | Programmer ready, gates CMP_HI |
| hash_ack_i | input | 1 | Hash engine acknowledge |
| hash_err_i | input | 1 | Hash error, valid with ack |
| hash_i | input | TOK_W | Hash result, valid with ack |
| wipe_ack_i | input | 1 | Flash wipe done |
| state_o | output | 4 | Decoded state index |
| clk_byp_o | output | 1 | Bypass clock selected |
| prog_req_o | output | 1 | Programmer request |
| prog_cnt_o | output | 1 | Programmer target is the counter |
| prog_tgt_o | output | LC_W | Captured target for state programming |
| hash_req_o | output | 1 | Hash request |
| hash_tok_o | output | TOK_W | Captured token for the hash engine |
| wipe_req_o | output | 1 | Flash wipe request |
| err_flow_o | output | 1 | Counter, programming or hash failure |
| err_trans_o | output | 1 | Illegal transition |
| err_tok_o | output | 1 | Token mismatch |

## Verification
The bound checker enforces several rules on every cycle. It checks escalation entry from any eligible state and the stickiness of ESC and SCRAP. It checks the forced move from RESET to IDLE, the routing of a corrupted code to INVALID, and the hold of CMP_HI while the programmer is not ready. It checks that at most one agent request is active and that the token flag rises only on entry to POST. Only the bench scenarios can show the end-to-end order of the pipeline, the values carried on hash_tok_o and prog_tgt_o, the RMA-only wipe, and which failure raises which flag. They are also the only way to show that scrap_i and late acknowledges are ignored outside the states that use them. The bench steps a reference model cycle by cycle against random handshake timing and random failures.

// File: rtl/xition_pkg.sv
package xition_pkg;

    localparam int NUM_ST = 15;
    localparam int CODE_W = 7;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_CLKMUX   = 4'd2,
        ST_CNT_INC  = 4'd3,
        ST_CNT_PROG = 4'd4,
        ST_LEGAL    = 4'd5,
        ST_HASH     = 4'd6,
        ST_WIPE     = 4'd7,
        ST_CMP_LO   = 4'd8,
        ST_CMP_HI   = 4'd9,
        ST_PROG     = 4'd10,
        ST_POST     = 4'd11,
        ST_SCRAP    = 4'd12,
        ST_ESC      = 4'd13,
        ST_INVALID  = 4'd14
    } fsm_st_e;

    typedef struct packed {
        logic flow;
        logic trans;
        logic tok;
    } err_flags_t;

    // Hamming(7,4) codeword of (index + 1): every pair differs in >= 3 bits
    function automatic logic [CODE_W-1:0] st_code(input logic [3:0] idx);
        logic [3:0] d;
        d = idx + 4'd1;
        return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
    endfunction

    function automatic logic in_flow(input fsm_st_e s);
        return (s >= ST_CLKMUX) && (s <= ST_PROG);
    endfunction

endpackage

// File: rtl/xition_state_reg.sv
module xition_state_reg
    import xition_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fsm_st_e nxt,
    output fsm_st_e cur,
    output logic    bad
);

    logic [CODE_W-1:0] code_q;
    logic [NUM_ST-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) code_q <= st_code(ST_RESET);
        else     code_q <= st_code(nxt);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_ST; g++) begin : g_match
            assign hit[g] = (code_q == st_code(4'(g)));
        end
    endgenerate

    always_comb begin
        cur = ST_INVALID;
        for (int i = 0; i < NUM_ST; i++) begin
            if (hit[i]) cur = fsm_st_e'(4'(i));
        end
    end

    assign bad = (hit == '0);

endmodule

// File: rtl/xition_tok_cmp.sv
module xition_tok_cmp #(
    parameter int TOK_W = 32,
    parameter int SEGS  = 2
) (
    input  logic [TOK_W-1:0] hash,
    input  logic [TOK_W-1:0] expv,
    output logic [SEGS-1:0]  seg_ok
);

    localparam int SEG_W = TOK_W / SEGS;

    genvar g;
    generate
        for (g = 0; g < SEGS; g++) begin : g_seg
            assign seg_ok[g] = (hash[g*SEG_W +: SEG_W] == expv[g*SEG_W +: SEG_W]);
        end
    endgenerate

endmodule

// File: rtl/xition_ctrl.sv
module xition_ctrl
    import xition_pkg::*;
#(
    parameter int LC_W    = 4,
    parameter int TOK_W   = 32,
    parameter int RMA_TGT = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [LC_W-1:0]  tgt_i,
    input  logic [LC_W-1:0]  cur_lc_i,
    input  logic [TOK_W-1:0] token_i,
    input  logic [TOK_W-1:0] exp_tok_i,
    input  logic             scrap_i,
    input  logic             esc0_i,
    input  logic             esc1_i,
    input  logic             cnt_full_i,
    input  logic             prog_ack_i,
    input  logic             prog_err_i,
    input  logic             prog_rdy_i,
    input  logic             hash_ack_i,
    input  logic             hash_err_i,
    input  logic [TOK_W-1:0] hash_i,
    input  logic             wipe_ack_i,
    output logic [3:0]       state_o,
    output logic             clk_byp_o,
    output logic             prog_req_o,
    output logic             prog_cnt_o,
    output logic [LC_W-1:0]  prog_tgt_o,
    output logic             hash_req_o,
    output logic [TOK_W-1:0] hash_tok_o,
    output logic             wipe_req_o,
    output logic             err_flow_o,
    output logic             err_trans_o,
    output logic             err_tok_o
);

    localparam int SEGS = 2;
    localparam logic [LC_W-1:0] RMA_CODE = LC_W'(RMA_TGT);

    fsm_st_e          cur_st, nxt_st;
    logic             code_bad;
    logic             esc;
    logic [SEGS-1:0]  seg_ok;
    logic [LC_W-1:0]  tgt_q;
    logic [TOK_W-1:0] tok_q, hash_q;
    err_flags_t       err_q, err_set;
    logic             cap_req, cap_hash, rma_sel;

    xition_state_reg u_sreg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st),
        .bad (code_bad)
    );

    xition_tok_cmp #(.TOK_W(TOK_W), .SEGS(SEGS)) u_cmp (
        .hash   (hash_q),
        .expv   (exp_tok_i),
        .seg_ok (seg_ok)
    );

    assign esc     = esc0_i | esc1_i;
    assign rma_sel = (tgt_q == RMA_CODE);

    always_comb begin
        nxt_st   = cur_st;
        err_set  = '0;
        cap_req  = 1'b0;
        cap_hash = 1'b0;
        if (code_bad) begin
            nxt_st = ST_INVALID;
        end else if (cur_st == ST_RESET) begin
            nxt_st = ST_IDLE;
        end else if (cur_st == ST_SCRAP) begin
            nxt_st = ST_SCRAP;
        end else if (esc) begin
            nxt_st = ST_ESC;
        end else begin
            unique case (cur_st)
                ST_IDLE: begin
                    if (scrap_i) nxt_st = ST_SCRAP;
                    else if (req_i) begin
                        nxt_st  = ST_CLKMUX;
                        cap_req = 1'b1;
                    end
                end
                ST_CLKMUX: nxt_st = ST_CNT_INC;
                ST_CNT_INC: begin
                    if (cnt_full_i) begin
                        nxt_st       = ST_POST;
                        err_set.flow = 1'b1;
                    end else nxt_st = ST_CNT_PROG;
                end
                ST_CNT_PROG: begin
                    if (prog_ack_i) begin
                        nxt_st       = prog_err_i ? ST_POST : ST_LEGAL;
                        err_set.flow = prog_err_i;
                    end
                end
                ST_LEGAL: begin
                    if (tgt_q > cur_lc_i) nxt_st = ST_HASH;
                    else begin
                        nxt_st        = ST_POST;
                        err_set.trans = 1'b1;
                    end
                end
                ST_HASH: begin
                    if (hash_ack_i) begin
                        nxt_st       = hash_err_i ? ST_POST : ST_WIPE;
                        err_set.flow = hash_err_i;
                        cap_hash     = ~hash_err_i;
                    end
                end
                ST_WIPE: begin
                    if (!rma_sel || wipe_ack_i) nxt_st = ST_CMP_LO;
                end
                ST_CMP_LO: begin
                    nxt_st      = seg_ok[0] ? ST_CMP_HI : ST_POST;
                    err_set.tok = ~seg_ok[0];
                end
                ST_CMP_HI: begin
                    if (prog_rdy_i) begin
                        nxt_st      = seg_ok[1] ? ST_PROG : ST_POST;
                        err_set.tok = ~seg_ok[1];
                    end
                end
                ST_PROG: begin
                    if (prog_ack_i) begin
                        nxt_st       = ST_POST;
                        err_set.flow = prog_err_i;
                    end
                end
                default: nxt_st = cur_st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            tok_q  <= '0;
            hash_q <= '0;
            err_q  <= '0;
        end else begin
            if (cap_req) begin
                tgt_q <= tgt_i;
                tok_q <= token_i;
            end
            if (cap_hash) hash_q <= hash_i;
            err_q <= err_q | err_set;
        end
    end

    assign state_o     = cur_st;
    assign clk_byp_o   = in_flow(cur_st);
    assign prog_req_o  = (cur_st == ST_CNT_PROG) || (cur_st == ST_PROG);
    assign prog_cnt_o  = (cur_st == ST_CNT_PROG);
    assign prog_tgt_o  = tgt_q;
    assign hash_req_o  = (cur_st == ST_HASH);
    assign hash_tok_o  = tok_q;
    assign wipe_req_o  = (cur_st == ST_WIPE) && rma_sel;
    assign err_flow_o  = err_q.flow;
    assign err_trans_o = err_q.trans;
    assign err_tok_o   = err_q.tok;

endmodule

// File: rtl/xition_chk.sv
module xition_chk
    import xition_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input fsm_st_e st,
    input logic    bad,
    input logic    esc0,
    input logic    esc1,
    input logic    prog_rdy,
    input logic    hash_req,
    input logic    prog_req,
    input logic    wipe_req,
    input logic    err_tok
);

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RESET && !bad) |=> st == ST_IDLE);

    // R9
    esc_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ((esc0 || esc1) && !bad && st != ST_RESET && st != ST_SCRAP) |=> st == ST_ESC);

    // R10
    esc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ESC && !bad) |=> st == ST_ESC);

    // R8
    scrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SCRAP && !bad) |=> st == ST_SCRAP);

    // R11
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        bad |=> (st == ST_INVALID && !bad));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMP_HI && !prog_rdy && !esc0 && !esc1 && !bad) |=> st == ST_CMP_HI);

    // R12
    agent_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hash_req, prog_req, wipe_req}));

    // R6
    tok_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_tok) |-> st == ST_POST);

endmodule

bind xition_ctrl xition_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (cur_st),
    .bad      (code_bad),
    .esc0     (esc0_i),
    .esc1     (esc1_i),
    .prog_rdy (prog_rdy_i),
    .hash_req (hash_req_o),
    .prog_req (prog_req_o),
    .wipe_req (wipe_req_o),
    .err_tok  (err_tok_o)
);

// File: tb/sim_xition_ctrl.sv
module sim_xition_ctrl;

    localparam int LC_W = 4;
    localparam int TOK_W = 32;
    localparam int RMA = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 0, scrap_i = 0, esc0_i = 0, esc1_i = 0, cnt_full_i = 0;
    logic prog_ack_i = 0, prog_err_i = 0, prog_rdy_i = 0;
    logic hash_ack_i = 0, hash_err_i = 0, wipe_ack_i = 0;
    logic [LC_W-1:0]  tgt_i = '0, cur_lc_i = '0;
    logic [TOK_W-1:0] token_i = '0, exp_tok_i = '0, hash_i = '0;
    logic [3:0]       state_o;
    logic clk_byp_o, prog_req_o, prog_cnt_o, hash_req_o, wipe_req_o;
    logic err_flow_o, err_trans_o, err_tok_o;
    logic [LC_W-1:0]  prog_tgt_o;
    logic [TOK_W-1:0] hash_tok_o;

    xition_ctrl #(.LC_W(LC_W), .TOK_W(TOK_W), .RMA_TGT(RMA)) u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .tgt_i(tgt_i), .cur_lc_i(cur_lc_i),
        .token_i(token_i), .exp_tok_i(exp_tok_i), .scrap_i(scrap_i),
        .esc0_i(esc0_i), .esc1_i(esc1_i), .cnt_full_i(cnt_full_i),
        .prog_ack_i(prog_ack_i), .prog_err_i(prog_err_i), .prog_rdy_i(prog_rdy_i),
        .hash_ack_i(hash_ack_i), .hash_err_i(hash_err_i), .hash_i(hash_i),
        .wipe_ack_i(wipe_ack_i), .state_o(state_o), .clk_byp_o(clk_byp_o),
        .prog_req_o(prog_req_o), .prog_cnt_o(prog_cnt_o), .prog_tgt_o(prog_tgt_o),
        .hash_req_o(hash_req_o), .hash_tok_o(hash_tok_o), .wipe_req_o(wipe_req_o),
        .err_flow_o(err_flow_o), .err_trans_o(err_trans_o), .err_tok_o(err_tok_o)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit fin = 0;

    int               m_st = 0;
    logic [LC_W-1:0]  m_tgt = '0;
    logic [TOK_W-1:0] m_tok = '0, m_hash = '0;
    bit m_flow = 0, m_trans = 0, m_tokerr = 0, m_bad = 0;
    string m_why = "R1";

    function automatic bit pct(int p);
        return ($urandom % 100) < p;
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", r, act, expv, $time);
        end
    endtask

    task automatic check_all();
        chk(m_why, 32'(state_o), 32'(m_st));
        chk("R4", 32'(err_flow_o), 32'(m_flow));
        chk("R5", 32'(err_trans_o), 32'(m_trans));
        chk("R6", 32'(err_tok_o), 32'(m_tokerr));
        chk("R12", 32'(hash_req_o), 32'(m_st == 6));
        chk("R12", 32'(prog_req_o), 32'(m_st == 4 || m_st == 10));
        chk("R12", 32'(prog_cnt_o), 32'(m_st == 4));
        chk("R12", 32'(clk_byp_o), 32'(m_st >= 2 && m_st <= 10));
        chk("R3", 32'(wipe_req_o), 32'(m_st == 7 && m_tgt == RMA));
        if (m_st == 6)  chk("R2", hash_tok_o, m_tok);
        if (m_st == 10) chk("R2", 32'(prog_tgt_o), 32'(m_tgt));
    endtask

    task automatic model_step();
        int n = m_st;
        m_why = "R2";
        if (rst) begin
            n = 0; m_flow = 0; m_trans = 0; m_tokerr = 0;
            m_tgt = '0; m_tok = '0; m_hash = '0; m_why = "R1";
        end else if (m_bad) begin
            n = 14; m_why = "R11";
        end else if (m_st == 0) begin
            n = 1; m_why = "R1";
        end else if (m_st == 12) begin
            m_why = "R8";
        end else if (esc0_i || esc1_i) begin
            n = 13; m_why = "R9";
        end else begin
            case (m_st)
                1: if (scrap_i) begin n = 12; m_why = "R8"; end
                   else if (req_i) begin n = 2; m_tgt = tgt_i; m_tok = token_i; end
                2: n = 3;
                3: if (cnt_full_i) begin n = 11; m_flow = 1; m_why = "R4"; end else n = 4;
                4: if (prog_ack_i) begin
                       if (prog_err_i) begin n = 11; m_flow = 1; m_why = "R4"; end else n = 5;
                   end
                5: if (m_tgt > cur_lc_i) n = 6; else begin n = 11; m_trans = 1; m_why = "R5"; end
                6: if (hash_ack_i) begin
                       if (hash_err_i) begin n = 11; m_flow = 1; m_why = "R4"; end
                       else begin n = 7; m_hash = hash_i; end
                   end
                7: begin m_why = "R3"; if (m_tgt != RMA || wipe_ack_i) n = 8; end
                8: if (m_hash[15:0] == exp_tok_i[15:0]) n = 9;
                   else begin n = 11; m_tokerr = 1; m_why = "R6"; end
                9: begin
                       m_why = "R7";
                       if (prog_rdy_i) begin
                           if (m_hash[31:16] == exp_tok_i[31:16]) n = 10;
                           else begin n = 11; m_tokerr = 1; m_why = "R6"; end
                       end
                   end
                10: if (prog_ack_i) begin n = 11; if (prog_err_i) m_flow = 1; end
                default: m_why = "R10";
            endcase
        end
        m_st = n;
    endtask

    task automatic episode(int ncyc, int p_req, int p_ack, int p_err, int p_scrap,
                           int esc_at, int p_mis, bit force_rma);
        logic [LC_W-1:0]  e_tgt, e_cur;
        logic [TOK_W-1:0] e_exp;
        int r, esel;
        e_tgt = force_rma ? LC_W'(RMA) : (pct(25) ? LC_W'(RMA) : LC_W'($urandom));
        e_cur = (pct(75) && e_tgt != 0) ? LC_W'($urandom % e_tgt) : LC_W'($urandom);
        e_exp = $urandom;
        esel = $urandom % 3;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            check_all();
            rst        = (c < 2);
            req_i      = pct(p_req);
            tgt_i      = e_tgt;
            cur_lc_i   = e_cur;
            exp_tok_i  = e_exp;
            token_i    = $urandom;
            scrap_i    = pct(p_scrap);
            esc0_i     = (c == esc_at) && (esel != 1);
            esc1_i     = (c == esc_at) && (esel != 0);
            cnt_full_i = pct(p_err);
            prog_ack_i = pct(p_ack);
            prog_err_i = pct(p_err);
            prog_rdy_i = pct(p_ack);
            hash_ack_i = pct(p_ack);
            hash_err_i = pct(p_err);
            wipe_ack_i = pct(p_ack);
            r = $urandom % 100;
            if (r < p_mis / 2)  hash_i = e_exp ^ 32'h0000_0001;
            else if (r < p_mis) hash_i = e_exp ^ 32'h0001_0000;
            else                hash_i = e_exp;
            model_step();
        end
    endtask

    task automatic quiet_cycle(bit esc);
        @(negedge clk);
        check_all();
        {req_i, scrap_i, esc1_i, esc0_i} = '0;
        esc1_i = esc;
        model_step();
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R2 clean pass, R3 RMA target with slow wipe
        episode(30, 100, 100, 0, 0, -1, 0, 0);
        episode(40, 100, 30, 0, 0, -1, 0, 1);
        // R8 scrap wins in idle, later escalation ignored
        episode(12, 100, 50, 0, 100, 6, 0, 0);
        // R1 escalation during reset state is not taken
        episode(8, 0, 50, 0, 0, 2, 0, 0);
        // R6 token mismatches, R7 slow ready
        episode(40, 100, 20, 0, 0, -1, 100, 0);
        // R11 corrupted state code
        episode(4, 0, 0, 0, 0, -1, 0, 0);
        @(negedge clk);
        check_all();
        u0.u_sreg.code_q = 7'h03;
        #1;
        chk("R11", 32'(state_o), 32'd14);
        {req_i, scrap_i, esc0_i, esc1_i} = '0;
        m_bad = 1;
        model_step();
        m_bad = 0;
        quiet_cycle(0);
        quiet_cycle(1);
        quiet_cycle(0);
        quiet_cycle(0);
        // random mix
        for (int e = 0; e < 300; e++) begin
            episode(40, 50, 50, 5, 3, pct(20) ? int'(2 + $urandom % 38) : -1, 20, 0);
        end
        @(negedge clk);
        check_all();
        fin = 1;
    end

    initial begin
        for (int w = 0; w < 100000; w++) begin
            @(posedge clk);
            if (fin) break;
        end
        if (!fin) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule